// File: doc/BRIEF.md
# Fuse Image Stability Checker

This block builds a trustworthy snapshot of a small one-time-programmable fuse image. It sits above a byte-serial read sequencer. The block asks the sequencer for full-image reads that always begin at address 0. The first read fills a local reference copy. Each later read is a verification pass that compares every returned byte against that reference.

The snapshot is accepted only after a fixed run of back-to-back passes in which no byte differs. The first differing byte spoils its pass. The remaining bytes of that pass are ignored, the reference is read again, the run of clean passes restarts from zero, and a mismatch counter goes up by one. When that counter reaches its budget, the block stops retrying. It writes zero into two designated bytes of the stored image and finishes with an error flag in place of the valid flag.

A controller pulses `start` and then waits for either `imgValid` or `imgError`. It then uses `imageOut`, in which byte k occupies bits [8k+7:8k].

Top module: `fuse_stable_read`

## Requirements
- R1: After reset, `imgValid`, `imgError` and `seqStart` are all low, and no read is requested until `start` is pulsed.
- R2: Every read request carries `seqAddr` = 0 and `seqLen` = NUM_BYTES (32). The first read after `start` is loaded byte by byte, in arrival order, into the reference image.
- R3: Each verification pass compares every byte returned by the sequencer with the reference byte at the same position. A pass is clean only when all of its bytes match.
- R4: `imgValid` rises once PASSES (10) consecutive clean passes have completed. With fault-free data, this takes exactly 1 + PASSES reads, and `imageOut` equals the fuse contents.
- R5: A mismatch on any byte, the last byte included, spoils its pass. The bytes that remain are ignored, the reference is read again, and the clean-pass run restarts at zero.
- R6: A corrupted reference read is repaired by the reload that follows the failed pass. The final image then matches the true fuse contents.
- R7: Each spoiled pass adds one to an error counter that never exceeds ERR_LIMIT (500). When the counter reaches ERR_LIMIT, no further read is requested and `imgError` rises. The total number of reads is then 2 × ERR_LIMIT.
- R8: When the block gives up, bytes FORCE_A (5) and FORCE_B (22) of `imageOut` become 0x00. All other bytes keep the last reference read.
- R9: While checking is in progress, both flags are low. On completion, exactly one of `imgValid` and `imgError` is high, and it holds until the next accepted `start`.
- R10: A `start` pulse that arrives while checking is in progress has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a checking run when the block is idle |
| seqStart | output | 1 | One-cycle request for a full-image read |
| seqAddr | output | ADDR_W | First byte address of the read (always 0) |
| seqLen | output | $clog2(NUM_BYTES+1) | Number of bytes to read |
| seqBusy | input | 1 | Sequencer is executing a read |
| seqDone | input | 1 | One-cycle pulse marking the end of a read |
| byteValid | input | 1 | A returned byte is present on `byteData` |
| byteData | input | 8 | Returned fuse byte, in ascending address order |
| imgValid | output | 1 | Image accepted as stable |
| imgError | output | 1 | Error budget exhausted; default bytes substituted |
| imageOut | output | NUM_BYTES*8 | Stored image, byte k at bits [8k+7:8k] |

## Verification
The assertions assume a well-behaved sequencer. It returns at most NUM_BYTES bytes per request, it raises `seqDone` only after a request, and it holds `seqBusy` high for the whole read. The bench's sequencer model keeps to this contract. It answers each request with one idle cycle, then exactly 32 consecutive bytes, then a single `seqDone` pulse, with busy covering the whole span. Corruption is applied only to byte values, never to the handshake. This keeps stimulus inside the timing the properties rely on while still reaching mismatches on the first, a middle and the last byte.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REF_REQ,
    S_REF_RD,
    S_CHK_REQ,
    S_CHK_RD
  } fsrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;    // new run: clear counters and mismatch flag
    logic idxClr;    // new read: rewind byte position
    logic loadByte;  // returned bytes fill the reference
    logic cmpByte;   // returned bytes are compared with the reference
    logic mmClr;     // forget mismatch of previous pass
    logic passInc;   // one more clean pass
    logic passClr;   // clean run broken
    logic errInc;    // one more spoiled pass
    logic forceDef;  // substitute default bytes
  } fsrStrobe_t;

endpackage

// File: rtl/fsr_dp.sv
module fsr_dp
  import fsr_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int PASSES    = 10,
  parameter int ERR_LIMIT = 500,
  parameter int FORCE_A   = 5,
  parameter int FORCE_B   = 22
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fsrStrobe_t             strb,
  input  logic                   byteValid,
  input  logic [7:0]             byteData,
  output logic                   mismatchNow,
  output logic                   passLast,
  output logic                   errLast,
  output logic [NUM_BYTES*8-1:0] imageOut
);

  localparam int AW    = $clog2(NUM_BYTES);
  localparam int IDX_W = $clog2(NUM_BYTES + 1);
  localparam int PW    = $clog2(PASSES + 1);
  localparam int EW    = $clog2(ERR_LIMIT + 1);

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    slot;
  logic             inRange;
  logic             byteTaken;
  logic             curDiff;
  logic             mmSeen;
  logic [PW-1:0]    passCnt;
  logic [EW-1:0]    errCnt;
  logic [7:0]       img [NUM_BYTES];

  assign inRange   = idx < IDX_W'(NUM_BYTES);
  assign slot      = idx[AW-1:0];
  assign byteTaken = byteValid && inRange && (strb.loadByte || strb.cmpByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            idx <= '0;
    else if (strb.idxClr) idx <= '0;
    else if (byteTaken)   idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        img[g] <= '0;
      else if (strb.forceDef && (g == FORCE_A || g == FORCE_B))
        img[g] <= '0;
      else if (strb.loadByte && byteValid && inRange && slot == AW'(g))
        img[g] <= byteData;
    end
    assign imageOut[g*8 +: 8] = img[g];
  end

  assign curDiff     = strb.cmpByte && byteValid && inRange && (byteData != img[slot]);
  assign mismatchNow = mmSeen || curDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          mmSeen <= 1'b0;
    else if (strb.clrAll || strb.mmClr) mmSeen <= 1'b0;
    else if (curDiff)                   mmSeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            passCnt <= '0;
    else if (strb.clrAll || strb.passClr) passCnt <= '0;
    else if (strb.passInc)                passCnt <= passCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        errCnt <= '0;
    else if (strb.clrAll)                             errCnt <= '0;
    else if (strb.errInc && errCnt < EW'(ERR_LIMIT))  errCnt <= errCnt + 1'b1;
  end

  assign passLast = passCnt == PW'(PASSES - 1);
  assign errLast  = errCnt == EW'(ERR_LIMIT - 1);

  // R7: error counter saturates at its budget
  a_r7_err_bound: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= EW'(ERR_LIMIT));

  // R4: clean run never passes the required length
  a_r4_pass_bound: assert property (@(posedge clk) disable iff (!rstN)
    passCnt <= PW'(PASSES));

  // R8: substitution leaves both designated bytes at zero
  a_r8_forced_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceDef |=> (img[FORCE_A] == 8'h00 && img[FORCE_B] == 8'h00));

  // R5: a detected mismatch stays recorded until the pass is closed
  a_r5_mm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    curDiff && !strb.mmClr && !strb.clrAll |=> mmSeen);

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       seqBusy,
  input  logic       seqDone,
  input  logic       mismatchNow,
  input  logic       passLast,
  input  logic       errLast,
  output fsrStrobe_t strb,
  output logic       seqStart,
  output logic       imgValid,
  output logic       imgError
);

  fsrState_t state, stateNx;
  logic      setValid, setError, clrFlags;

  always_comb begin
    stateNx  = state;
    strb     = '0;
    seqStart = 1'b0;
    setValid = 1'b0;
    setError = 1'b0;
    clrFlags = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.clrAll = 1'b1;
        clrFlags    = 1'b1;
        stateNx     = S_REF_REQ;
      end
      S_REF_REQ: if (!seqBusy) begin
        seqStart    = 1'b1;
        strb.idxClr = 1'b1;
        stateNx     = S_REF_RD;
      end
      S_REF_RD: begin
        strb.loadByte = 1'b1;
        if (seqDone) stateNx = S_CHK_REQ;
      end
      S_CHK_REQ: if (!seqBusy) begin
        seqStart    = 1'b1;
        strb.idxClr = 1'b1;
        strb.mmClr  = 1'b1;
        stateNx     = S_CHK_RD;
      end
      S_CHK_RD: begin
        strb.cmpByte = 1'b1;
        if (seqDone) begin
          if (mismatchNow) begin
            strb.errInc  = 1'b1;
            strb.passClr = 1'b1;
            if (errLast) begin
              strb.forceDef = 1'b1;
              setError      = 1'b1;
              stateNx       = S_IDLE;
            end else begin
              stateNx = S_REF_REQ;
            end
          end else begin
            strb.passInc = 1'b1;
            if (passLast) begin
              setValid = 1'b1;
              stateNx  = S_IDLE;
            end else begin
              stateNx = S_CHK_REQ;
            end
          end
        end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      imgValid <= 1'b0;
      imgError <= 1'b0;
    end else begin
      state <= stateNx;
      if (clrFlags) begin
        imgValid <= 1'b0;
        imgError <= 1'b0;
      end
      if (setValid) imgValid <= 1'b1;
      if (setError) imgError <= 1'b1;
    end
  end

  // R9: never both flags
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(imgValid && imgError));

  // R9: flags low while a run is active
  a_r9_low_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (!imgValid && !imgError));

  // R9: a raised flag holds until the next start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (imgValid || imgError) && !start |=> $stable({imgValid, imgError}));

  // R10: start during a run does not rewind the sequence
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    start && state == S_CHK_RD && !seqDone |=> state == S_CHK_RD);

endmodule

// File: rtl/fuse_stable_read.sv
module fuse_stable_read
  import fsr_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int PASSES    = 10,
  parameter int ERR_LIMIT = 500,
  parameter int FORCE_A   = 5,
  parameter int FORCE_B   = 22,
  parameter int ADDR_W    = 8,
  localparam int LEN_W    = $clog2(NUM_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  output logic                   seqStart,
  output logic [ADDR_W-1:0]      seqAddr,
  output logic [LEN_W-1:0]       seqLen,
  input  logic                   seqBusy,
  input  logic                   seqDone,
  input  logic                   byteValid,
  input  logic [7:0]             byteData,
  output logic                   imgValid,
  output logic                   imgError,
  output logic [NUM_BYTES*8-1:0] imageOut
);

  fsrStrobe_t strb;
  logic       mismatchNow, passLast, errLast;

  assign seqAddr = '0;
  assign seqLen  = LEN_W'(NUM_BYTES);

  fsr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .seqBusy     (seqBusy),
    .seqDone     (seqDone),
    .mismatchNow (mismatchNow),
    .passLast    (passLast),
    .errLast     (errLast),
    .strb        (strb),
    .seqStart    (seqStart),
    .imgValid    (imgValid),
    .imgError    (imgError)
  );

  fsr_dp #(
    .NUM_BYTES (NUM_BYTES),
    .PASSES    (PASSES),
    .ERR_LIMIT (ERR_LIMIT),
    .FORCE_A   (FORCE_A),
    .FORCE_B   (FORCE_B)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .mismatchNow (mismatchNow),
    .passLast    (passLast),
    .errLast     (errLast),
    .imageOut    (imageOut)
  );

endmodule

// File: tb/fuse_stable_read_tb.sv
module fuse_stable_read_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          seqStart;
  logic [7:0]    seqAddr;
  logic [5:0]    seqLen;
  logic          seqBusy = 1'b0;
  logic          seqDone = 1'b0;
  logic          byteValid = 1'b0;
  logic [7:0]    byteData = '0;
  logic          imgValid, imgError;
  logic [NB*8-1:0] imageOut;

  int checks = 0;
  int fails  = 0;

  // sequencer model state
  int   reads = 0;
  int   relBase = 0;
  int   curRead = 0;
  int   mState = 0;
  int   k = 0;
  int   mode = 0;        // 0 clean, 1 single glitch, 2 odd reads corrupted
  int   glitchRead = -1;
  int   glitchByte = 0;
  int   addrSeen = 0;
  int   lenSeen = 0;
  logic [7:0] fuseMem [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_stable_read u_dut (
    .clk (clk), .rstN (rstN), .start (start),
    .seqStart (seqStart), .seqAddr (seqAddr), .seqLen (seqLen),
    .seqBusy (seqBusy), .seqDone (seqDone),
    .byteValid (byteValid), .byteData (byteData),
    .imgValid (imgValid), .imgError (imgError), .imageOut (imageOut)
  );

  function automatic logic [7:0] fuseByte(int rd, int idx);
    logic [7:0] b = fuseMem[idx];
    if (mode == 1 && rd == glitchRead && idx == glitchByte) b = b ^ 8'h5A;
    if (mode == 2 && rd[0] && idx == 0) b = b ^ 8'hFF;
    return b;
  endfunction

  always @(posedge clk) begin
    case (mState)
      0: begin
        seqDone <= 1'b0;
        if (seqStart) begin
          curRead  <= reads - relBase;
          reads    <= reads + 1;
          addrSeen <= int'(seqAddr);
          lenSeen  <= int'(seqLen);
          seqBusy  <= 1'b1;
          mState   <= 1;
        end
      end
      1: begin k <= 0; mState <= 2; end
      2: begin
        byteValid <= 1'b1;
        byteData  <= fuseByte(curRead, k);
        k <= k + 1;
        if (k == NB - 1) mState <= 3;
      end
      default: begin
        byteValid <= 1'b0;
        seqDone   <= 1'b1;
        seqBusy   <= 1'b0;
        mState    <= 0;
      end
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic launch();
    relBase = reads;
    pulseStart();
  endtask

  task automatic waitEnd();
    int n = 0;
    while (!(imgValid || imgError) && n < 120000) begin
      @(negedge clk); n++;
    end
  endtask

  // bytes that differ from the expected image, skipping forced ones if asked
  function automatic int imgDiffs(bit forced);
    int d = 0;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] e = fuseMem[i];
      if (forced && (i == 5 || i == 22)) e = 8'h00;
      if (imageOut[i*8 +: 8] != e) d++;
    end
    return d;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(!imgValid && !imgError, "R1 flags after reset", {imgValid, imgError}, 0);
    check(!seqStart && reads == 0, "R1 no request before start", reads, 0);
  endtask

  task automatic t_clean();
    mode = 0;
    launch();
    repeat (50) @(negedge clk);
    check(!imgValid && !imgError, "R9 flags low during run", {imgValid, imgError}, 0);
    waitEnd();
    check(addrSeen == 0 && lenSeen == NB, "R2 request address and length", addrSeen*100+lenSeen, NB);
    check(imgValid && !imgError, "R4 valid after clean passes", {imgValid, imgError}, 2);
    check(reads - relBase == 11, "R4 read count clean", reads - relBase, 11);
    check(imgDiffs(0) == 0, "R2 R3 image matches fuses", imgDiffs(0), 0);
    repeat (20) @(negedge clk);
    check(imgValid && !imgError, "R9 valid holds", {imgValid, imgError}, 2);
  endtask

  task automatic t_glitch(input int rd, input int by, input int expReads, input string req);
    mode = 1; glitchRead = rd; glitchByte = by;
    launch();
    waitEnd();
    check(imgValid && !imgError, {req, " valid after retry"}, {imgValid, imgError}, 2);
    check(reads - relBase == expReads, {req, " read count"}, reads - relBase, expReads);
    check(imgDiffs(0) == 0, {req, " image correct"}, imgDiffs(0), 0);
  endtask

  task automatic t_start_ignored();
    mode = 0;
    launch();
    repeat (120) @(negedge clk);
    pulseStart();
    waitEnd();
    check(reads - relBase == 11, "R10 start during run ignored", reads - relBase, 11);
  endtask

  task automatic t_fail();
    mode = 2;
    launch();
    waitEnd();
    check(imgError && !imgValid, "R7 error after budget", {imgValid, imgError}, 1);
    repeat (100) @(negedge clk);
    check(reads - relBase == 1000, "R7 no reads beyond budget", reads - relBase, 1000);
    check(imageOut[5*8 +: 8] == 8'h00 && imageOut[22*8 +: 8] == 8'h00, "R8 forced bytes zero",
          int'(imageOut[5*8 +: 8]), 0);
    check(imgDiffs(1) == 0, "R8 other bytes from reference", imgDiffs(1), 0);
    check(imgError && !imgValid, "R9 error holds", {imgValid, imgError}, 1);
  endtask

  task automatic t_restart();
    mode = 0;
    launch();
    @(negedge clk);
    check(!imgError && !imgValid, "R9 start clears flags", {imgValid, imgError}, 0);
    waitEnd();
    check(imgValid && !imgError, "R9 valid after restart", {imgValid, imgError}, 2);
    check(imgDiffs(0) == 0, "R6 image restored after restart", imgDiffs(0), 0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) fuseMem[i] = 8'((i * 37 + 11) ^ 8'hA5);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_clean();
    t_glitch(3, 7, 15, "R5 mid-byte mismatch");
    t_glitch(0, 3, 13, "R6 corrupted reference");
    t_glitch(5, NB - 1, 17, "R5 last-byte mismatch");
    t_start_ignored();
    t_fail();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule